// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Decoder

This block is the digital front end of a two-channel 10-bit DAC. A host writes 16-bit command words over a three-wire serial link made of an active-low chip select, a serial clock and a data line. The block runs on its own system clock. It samples the three serial lines through synchronizers and detects their edges. It collects the word MSB first and acts on the word when chip select returns high.

Each channel has two registers. The input register holds staged data. The DAC register holds the value that drives the converter. Commands can stage data, move staged data into the DAC register, write both registers at once, or update both channels together. The block also holds a shutdown flag for each channel and a global bias power-down flag. A further bit chooses which serial clock edge moves the DOUT line.

DOUT carries the bit that leaves the far end of the shift register, delayed by one stage. This allows several devices to be daisy-chained on one link.

Top module: `dual_dac_cmd`

## Requirements
- R1: Synchronous reset sets both input registers and both DAC registers to zero, clears both shutdown flags and bias_off, selects the falling DOUT edge (dout_on_rise = 0) and drives dout to 0.
- R2: While cs_n is low, each rising sclk edge shifts din into the word, MSB first. The word is laid out as follows: bits [15:13] are the opcode, bits [12:3] are the data field (data bit 9 at word bit 12), and bits [2:0] are ignored. sclk edges while cs_n is high change nothing. The command takes effect when cs_n rises.
- R3: If cs_n rises after any number of rising sclk edges other than 16, the frame is discarded and no register changes.
- R4: Opcode 001 loads input register A with the data field. Opcode 101 loads input register B. Both DAC registers keep their values.
- R5: Opcode 010 loads input register A and opcode 110 loads input register B. In both cases, each DAC register then takes its own input register's new value.
- R6: Opcode 011 writes the data field into all four registers. Opcode 100 copies each input register into its DAC register and ignores the data field.
- R7: Opcode 111 sets shdn_a from data bit 9 and shdn_b from data bit 8, where 1 means shut down. bias_off is unchanged.
- R8: With opcode 000, data bits 9..7 form an extension code. Code 001 copies input A to DAC A. Code 101 copies input B to DAC B.
- R9: With opcode 000, extension code 011 sets bias_off, sets shdn_a from data bit 6 and sets shdn_b from data bit 5. Code 110 sets shdn_a from data bit 6. Code 111 sets shdn_b from data bit 6.
- R10: Any command that writes a channel's DAC register clears that channel's shutdown flag and clears bias_off.
- R11: With opcode 000 and extension code 100, data bit 6 sets dout_on_rise. When it is 0, dout moves on falling sclk edges. When it is 1, dout moves on rising sclk edges.
- R12: On each rising sclk edge inside a frame, the bit leaving the MSB of the shift register is captured. dout presents that bit on the selected edge, so during a frame dout replays the previous 16 shifted bits, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| dout | output | 1 | Daisy-chain serial data out |
| dac_a | output | 10 | DAC register A |
| dac_b | output | 10 | DAC register B |
| shdn_a | output | 1 | Channel A shut down |
| shdn_b | output | 1 | Channel B shut down |
| bias_off | output | 1 | Global bias powered down |
| dout_on_rise | output | 1 | DOUT edge select (1 = rising) |

## Verification
The bench sends 15-bit and 17-bit frames. A decoder that acted on any chip-select rise would write registers from a partial or shifted word. Staged data is moved into the DAC registers with separate commands, so the bench can see whether the input registers were wrongly written or forwarded. The bench also pulses sclk while chip select is high. A design that shifted during that time would misalign the bits that DOUT replays in the next frame. DOUT is checked in both edge modes, so a design stuck in one mode, or one that drops the one-stage delay, returns a wrong replay word.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int OP_W  = 3;
  localparam int SUB_W = 3;
  localparam int NCH   = 2;

  localparam logic [2:0] OP_EXT      = 3'b000;
  localparam logic [2:0] OP_LD_A     = 3'b001;
  localparam logic [2:0] OP_LD_A_UPD = 3'b010;
  localparam logic [2:0] OP_LD_ALL   = 3'b011;
  localparam logic [2:0] OP_UPD_ALL  = 3'b100;
  localparam logic [2:0] OP_LD_B     = 3'b101;
  localparam logic [2:0] OP_LD_B_UPD = 3'b110;
  localparam logic [2:0] OP_SHDN     = 3'b111;

  localparam logic [2:0] EX_UPD_A  = 3'b001;
  localparam logic [2:0] EX_FULLPD = 3'b011;
  localparam logic [2:0] EX_EDGE   = 3'b100;
  localparam logic [2:0] EX_UPD_B  = 3'b101;
  localparam logic [2:0] EX_SD_A   = 3'b110;
  localparam logic [2:0] EX_SD_B   = 3'b111;

  typedef struct packed {
    logic [NCH-1:0] ld_in;
    logic [NCH-1:0] upd;
    logic [NCH-1:0] sd_wr;
    logic [NCH-1:0] sd_val;
    logic           pd_set;
    logic           edge_wr;
    logic           edge_val;
  } cmd_t;
endpackage

// File: rtl/dual_dac_sync.sv
module dual_dac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic cs_hi,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din_s
);
  logic [STAGES-1:0] cs_p, ck_p, d_p;
  logic cs_q, ck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '1;
      ck_p <= '0;
      d_p  <= '0;
      cs_q <= 1'b1;
      ck_q <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_n};
      ck_p <= {ck_p[STAGES-2:0], sclk};
      d_p  <= {d_p[STAGES-2:0], din};
      cs_q <= cs_p[STAGES-1];
      ck_q <= ck_p[STAGES-1];
    end
  end

  assign cs_hi     = cs_p[STAGES-1];
  assign cs_rise   = cs_p[STAGES-1] & ~cs_q;
  assign sclk_rise = ck_p[STAGES-1] & ~ck_q;
  assign sclk_fall = ~ck_p[STAGES-1] & ck_q;
  assign din_s     = d_p[STAGES-1];
endmodule

// File: rtl/dual_dac_shift.sv
module dual_dac_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din_s,
  input  logic              mode_rise,
  output logic [WORD_W-1:0] word,
  output logic              frame_ok,
  output logic              dout
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      pend <= 1'b0;
      dout <= 1'b0;
    end else if (cs_hi) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      sh   <= {sh[WORD_W-2:0], din_s};
      pend <= sh[WORD_W-1];
      if (cnt != SAT) cnt <= cnt + 1'b1;
      if (mode_rise) dout <= sh[WORD_W-1];
    end else if (sclk_fall && !mode_rise) begin
      dout <= pend;
    end
  end

  assign word     = sh;
  assign frame_ok = cs_rise && (cnt == FULL);
endmodule

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
  import dual_dac_pkg::*;
#(
  parameter int DATA_W = 10,
  localparam int WORD_W = OP_W + DATA_W + SUB_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output cmd_t              cmd
);
  logic [OP_W-1:0] op;
  logic [2:0]      ext;
  logic            p_hi, p_lo, b6, b5;
  logic            unused_sub;

  assign op   = word[WORD_W-1 -: OP_W];
  assign data = word[SUB_W +: DATA_W];
  assign ext  = data[DATA_W-1 -: 3];
  assign p_hi = data[DATA_W-1];
  assign p_lo = data[DATA_W-2];
  assign b6   = data[DATA_W-4];
  assign b5   = data[DATA_W-5];
  assign unused_sub = ^word[SUB_W-1:0];

  always_comb begin
    cmd = '0;
    unique case (op)
      OP_LD_A:     cmd.ld_in = 2'b01;
      OP_LD_B:     cmd.ld_in = 2'b10;
      OP_LD_A_UPD: begin cmd.ld_in = 2'b01; cmd.upd = 2'b11; end
      OP_LD_B_UPD: begin cmd.ld_in = 2'b10; cmd.upd = 2'b11; end
      OP_LD_ALL:   begin cmd.ld_in = 2'b11; cmd.upd = 2'b11; end
      OP_UPD_ALL:  cmd.upd = 2'b11;
      OP_SHDN: begin
        cmd.sd_wr  = 2'b11;
        cmd.sd_val = {p_lo, p_hi};
      end
      OP_EXT: begin
        unique case (ext)
          EX_UPD_A:  cmd.upd = 2'b01;
          EX_UPD_B:  cmd.upd = 2'b10;
          EX_FULLPD: begin
            cmd.pd_set = 1'b1;
            cmd.sd_wr  = 2'b11;
            cmd.sd_val = {b5, b6};
          end
          EX_SD_A:   begin cmd.sd_wr = 2'b01; cmd.sd_val = {1'b0, b6}; end
          EX_SD_B:   begin cmd.sd_wr = 2'b10; cmd.sd_val = {b6, 1'b0}; end
          EX_EDGE:   begin cmd.edge_wr = 1'b1; cmd.edge_val = b6; end
          default:   cmd = '0;
        endcase
      end
      default: cmd = '0;
    endcase
  end
endmodule

// File: rtl/dual_dac_chan.sv
module dual_dac_chan #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              ld,
  input  logic              upd,
  input  logic              sd_wr,
  input  logic              sd_val,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] dac,
  output logic              sd
);
  logic [DATA_W-1:0] in_r, in_nx;

  assign in_nx = ld ? data : in_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_r <= '0;
      dac  <= '0;
      sd   <= 1'b0;
    end else if (commit) begin
      if (ld)    in_r <= data;
      if (upd)   dac  <= in_nx;
      if (sd_wr) sd   <= sd_val;
      else if (upd) sd <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_dac_cmd.sv
module dual_dac_cmd
  import dual_dac_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              shdn_a,
  output logic              shdn_b,
  output logic              bias_off,
  output logic              dout_on_rise
);
  localparam int WORD_W = OP_W + DATA_W + SUB_W;

  logic              cs_hi_s, cs_rise_s, ck_rise_s, ck_fall_s, din_s;
  logic [WORD_W-1:0] shreg;
  logic              frame_ok;
  logic [DATA_W-1:0] data;
  cmd_t              cmd;
  logic [DATA_W-1:0] dac_v [NCH];
  logic [NCH-1:0]    sd_v;

  dual_dac_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cs_hi(cs_hi_s), .cs_rise(cs_rise_s), .sclk_rise(ck_rise_s),
    .sclk_fall(ck_fall_s), .din_s(din_s)
  );

  dual_dac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .cs_hi(cs_hi_s), .cs_rise(cs_rise_s),
    .sclk_rise(ck_rise_s), .sclk_fall(ck_fall_s), .din_s(din_s),
    .mode_rise(dout_on_rise), .word(shreg), .frame_ok(frame_ok), .dout(dout)
  );

  dual_dac_decode #(.DATA_W(DATA_W)) u_dec (
    .word(shreg), .data(data), .cmd(cmd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dual_dac_chan #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst(rst), .commit(frame_ok),
      .ld(cmd.ld_in[c]), .upd(cmd.upd[c]),
      .sd_wr(cmd.sd_wr[c]), .sd_val(cmd.sd_val[c]),
      .data(data), .dac(dac_v[c]), .sd(sd_v[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bias_off     <= 1'b0;
      dout_on_rise <= 1'b0;
    end else if (frame_ok) begin
      if (cmd.pd_set)   bias_off <= 1'b1;
      else if (|cmd.upd) bias_off <= 1'b0;
      if (cmd.edge_wr)  dout_on_rise <= cmd.edge_val;
    end
  end

  assign dac_a  = dac_v[0];
  assign dac_b  = dac_v[1];
  assign shdn_a = sd_v[0];
  assign shdn_b = sd_v[1];
endmodule

// File: rtl/dual_dac_cmd_chk.sv
module dual_dac_cmd_chk #(
  parameter int DATA_W = 10,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_hi,
  input logic              commit,
  input logic [WORD_W-1:0] sh,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              shdn_a,
  input logic              shdn_b,
  input logic              bias_off
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dac_a == '0) && (dac_b == '0) && !shdn_a && !shdn_b && !bias_off);

  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(commit)) |->
      ($stable(dac_a) && $stable(dac_b) && $stable(shdn_a) &&
       $stable(shdn_b) && $stable(bias_off)));

  a_r2_no_shift_cs_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cs_hi)) |-> $stable(sh));

  a_r10_update_wakes_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (dac_a != $past(dac_a))) |-> (!shdn_a && !bias_off));

  a_r10_update_wakes_b: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (dac_b != $past(dac_b))) |-> (!shdn_b && !bias_off));
endmodule

bind dual_dac_cmd dual_dac_cmd_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .cs_hi(cs_hi_s), .commit(frame_ok), .sh(shreg),
  .dac_a(dac_a), .dac_b(dac_b), .shdn_a(shdn_a), .shdn_b(shdn_b),
  .bias_off(bias_off)
);

// File: tb/test_dual_dac_cmd.sv
`timescale 1ns/1ps
module test_dual_dac_cmd;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, shdn_a, shdn_b, bias_off, dout_on_rise;
  logic [9:0] dac_a, dac_b;
  int checks = 0, fails = 0;
  bit done = 0;
  logic rs [16];
  logic fs [16];

  always #2.5 clk = ~clk;

  dual_dac_cmd i_dual_dac_cmd (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
    .dac_a(dac_a), .dac_b(dac_b), .shdn_a(shdn_a), .shdn_b(shdn_b),
    .bias_off(bias_off), .dout_on_rise(dout_on_rise)
  );

  typedef struct packed {
    logic [15:0] w;
    logic [9:0]  a;
    logic [9:0]  b;
    logic        sa, sb, pd, md;
  } vec_t;

  // word, dac_a, dac_b, shdn_a, shdn_b, bias_off, dout_on_rise (state after word)
  localparam vec_t VEC [18] = '{
    '{16'h2AA8, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 load A
    '{16'hB550, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 load B
    '{16'h9FF8, 10'h155, 10'h2AA, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 update all, data ignored
    '{16'hF000, 10'h155, 10'h2AA, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 shutdown A only
    '{16'h4780, 10'h0F0, 10'h2AA, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 R10 load A, update all
    '{16'hDFF8, 10'h0F0, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 load B, update all
    '{16'h2088, 10'h0F0, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 stage A
    '{16'h0400, 10'h011, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 update A only
    '{16'hB110, 10'h011, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 stage B
    '{16'h1400, 10'h011, 10'h222, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 update B only
    '{16'h0E00, 10'h011, 10'h222, 1'b1, 1'b0, 1'b1, 1'b0}, // R9 full power-down
    '{16'h1E00, 10'h011, 10'h222, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 shutdown B
    '{16'h1800, 10'h011, 10'h222, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 wake A
    '{16'h6D28, 10'h1A5, 10'h1A5, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 R10 load all
    '{16'h1200, 10'h1A5, 10'h1A5, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 rising edge
    '{16'hE800, 10'h1A5, 10'h1A5, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 shutdown B only
    '{16'h1000, 10'h1A5, 10'h1A5, 1'b0, 1'b1, 1'b0, 1'b0}, // R11 falling edge
    '{16'h8000, 10'h1A5, 10'h1A5, 1'b0, 1'b0, 1'b0, 1'b0}  // R10 update all wakes B
  };

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    cs_n = 1'b0;
    hold(6);
    for (int i = 0; i < n; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      hold(6);
      sclk = 1'b1;
      hold(6);
      if (i < 16) rs[i] = dout;
      sclk = 1'b0;
      hold(6);
      if (i < 16) fs[i] = dout;
    end
    cs_n = 1'b1;
    hold(12);
  endtask

  function automatic logic [15:0] pack_fs();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[15-i] = fs[i];
    return v;
  endfunction

  function automatic logic [15:0] pack_rs();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[15-i] = rs[i];
    return v;
  endfunction

  initial begin
    logic dsave;
    hold(5);
    rst = 1'b0;
    hold(2);
    // R1 reset state
    check("R1 dac_a", 32'(dac_a), 32'h0);
    check("R1 dac_b", 32'(dac_b), 32'h0);
    check("R1 shutdown flags", 32'({shdn_a, shdn_b}), 32'h0);
    check("R1 bias_off", 32'(bias_off), 32'h0);
    check("R1 dout_on_rise", 32'(dout_on_rise), 32'h0);
    check("R1 dout", 32'(dout), 32'h0);

    // R2 R4 R5 R6 R7 R8 R9 R10 R11 vector walk
    for (int k = 0; k < 18; k++) begin
      send(VEC[k].w, 16);
      check($sformatf("R2 vec%0d dac_a", k), 32'(dac_a), 32'(VEC[k].a));
      check($sformatf("R2 vec%0d dac_b", k), 32'(dac_b), 32'(VEC[k].b));
      check($sformatf("R7 R9 vec%0d shdn_a", k), 32'(shdn_a), 32'(VEC[k].sa));
      check($sformatf("R7 R9 vec%0d shdn_b", k), 32'(shdn_b), 32'(VEC[k].sb));
      check($sformatf("R9 R10 vec%0d bias_off", k), 32'(bias_off), 32'(VEC[k].pd));
      check($sformatf("R11 vec%0d dout_on_rise", k), 32'(dout_on_rise), 32'(VEC[k].md));
    end

    // R3 short frame (would stage 3FF into A) is dropped
    send(16'h3FF8, 15);
    send(16'h8000, 16);
    check("R3 short frame dropped", 32'(dac_a), 32'h1A5);
    // R3 long frame (would load all) is dropped
    send(16'h6550, 17);
    check("R3 long frame dropped A", 32'(dac_a), 32'h1A5);
    check("R3 long frame dropped B", 32'(dac_b), 32'h1A5);

    // R6 load all, then sclk pulses with cs_n high
    send(16'h6618, 16);
    check("R6 load all 0C3", 32'({dac_a, dac_b}), 32'({10'h0C3, 10'h0C3}));
    dsave = dout;
    din = 1'b1;
    for (int p = 0; p < 3; p++) begin
      sclk = 1'b1; hold(6); sclk = 1'b0; hold(6);
    end
    din = 1'b0;
    check("R2 dout idle while cs_n high", 32'(dout), 32'(dsave));
    // R12 falling-edge replay of previous word, shift not disturbed (R2)
    send(16'h8000, 16);
    check("R12 falling-edge replay", 32'(pack_fs()), 32'h6618);
    begin
      int bad = 0;
      for (int i = 1; i < 16; i++) if (rs[i] !== 1'(16'h6618 >> (16 - i))) bad++;
      check("R11 falling mode holds across rise", 32'(bad), 32'h0);
    end

    // R11 R12 rising-edge replay
    send(16'h1200, 16);
    check("R11 rising mode set", 32'(dout_on_rise), 32'h1);
    send(16'h2AA8, 16);
    send(16'h8000, 16);
    check("R12 rising-edge replay", 32'(pack_rs()), 32'h2AA8);
    check("R6 update all after stage", 32'(dac_a), 32'h155);

    // R1 reset in mid-run
    rst = 1'b1;
    hold(3);
    rst = 1'b0;
    hold(2);
    check("R1 reset dacs", 32'({dac_a, dac_b}), 32'h0);
    check("R1 reset mode", 32'(dout_on_rise), 32'h0);
    check("R1 reset flags", 32'({shdn_a, shdn_b, bias_off}), 32'h0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule